// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single start request into the sequence of column addresses that a memory burst visits. A start strobe carries an 8-bit starting column, a 3-bit length code and an ordering bit. On the next cycle the block presents the first column. It then steps through the burst one beat at a time. Each beat stays inside an aligned block whose size equals the burst length. Only the low bits move, and they wrap at the block edge. The order is either a modular count or an XOR walk.

The beat output is a valid/ready stream. A beat is taken on a clock edge where `beat_vld` and `beat_rdy` are both high. While `beat_rdy` is low, the presented column and its flags hold still, so the consumer may stall for any number of cycles. A full-row burst runs until a terminate request ends it. A fresh start strobe is honoured on any cycle and replaces whatever burst was running. A start with an unusable setting raises a one-cycle error pulse and produces no beats.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `beat_vld`, `beat_last` and `cfg_err` are low.
- R2: `len_code` value 0, 1, 2 or 3 selects a burst of 1, 2, 4 or 8 beats, and value 7 selects a full-row burst. A legal start raises `beat_vld` on the following cycle, with `col` equal to `start_col`.
- R3: With `ilv_mode`=0 and burst length L, beat k presents the upper column bits of `start_col` unchanged. Its low log2(L) bits are (start low bits + k) mod L.
- R4: With `ilv_mode`=1 and burst length L, beat k keeps the upper bits of `start_col`. Its low log2(L) bits are the start low bits XOR k.
- R5: For a one-beat burst, `ilv_mode` has no effect: the single beat is `start_col`, flagged last.
- R6: A full-row burst (code 7, `ilv_mode`=0) presents (start_col + k) mod 256. It never raises `beat_last` and continues until terminated.
- R7: `beat_last` is high exactly on beat L-1 of a fixed-length burst. Once that beat is taken, `beat_vld` is low on the next cycle.
- R8: `term` high without `start_vld` ends the burst: `beat_vld` is low on the next cycle.
- R9: `start_vld` is accepted in any cycle, including during a burst. The new burst's first column appears on the next cycle, and the old burst is abandoned.
- R10: A start with `len_code` 4, 5 or 6, or with code 7 and `ilv_mode`=1, raises `cfg_err` for exactly one cycle and leaves `beat_vld` low.
- R11: While `beat_vld` is high and `beat_rdy` is low, with no start and no terminate, `col` and `beat_last` hold, and `beat_vld` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | 1 | Start a new burst this cycle |
| start_col | input | 8 | Starting column |
| len_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 1 = XOR order, 0 = counting order |
| term | input | 1 | End the current burst |
| beat_rdy | input | 1 | Consumer takes the presented beat |
| col | output | 8 | Column of the presented beat |
| beat_vld | output | 1 | A beat is presented |
| beat_last | output | 1 | Presented beat is the final one |
| cfg_err | output | 1 | One-cycle pulse for an unusable start |

## Verification
The bench uses starts whose low bits are non-zero, so wrap inside the aligned block is exercised. A design that carried out of the block would present a column in the neighbouring block. An XOR walk from an odd start separates the interleaved order from a plain count. The full-row burst crosses column 255 to 0, which catches a counter that is confined to a sub-block or that raises a last flag. Toggled back-pressure, a mid-burst restart and the illegal settings show whether a design skips beats under a stall, lets an old burst continue, or emits beats for a rejected start.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] LC_ONE  = 3'd0;
  localparam logic [CODE_W-1:0] LC_TWO  = 3'd1;
  localparam logic [CODE_W-1:0] LC_FOUR = 3'd2;
  localparam logic [CODE_W-1:0] LC_EIGHT = 3'd3;
  localparam logic [CODE_W-1:0] LC_ROW  = 3'd7;
endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic              ilv,
  output logic              legal,
  output logic              full,
  output logic [COL_W-1:0]  mask
);
  logic known;
  always_comb begin
    known = 1'b1;
    full  = 1'b0;
    mask  = '0;
    unique case (code)
      LC_ONE:   mask = '0;
      LC_TWO:   mask = COL_W'(1);
      LC_FOUR:  mask = COL_W'(3);
      LC_EIGHT: mask = COL_W'(7);
      LC_ROW: begin
        mask = '1;
        full = 1'b1;
      end
      default:  known = 1'b0;
    endcase
    legal = known && !(full && ilv);
  end
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] xor_w;
  assign sum_w = base + beat;
  assign xor_w = base ^ beat;
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (ilv ? xor_w[b] : sum_w[b]) : base[b];
  end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  logic             full_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             ilv_in,
  input  logic [COL_W-1:0] start_col,
  input  logic             term,
  input  logic             adv,
  output logic             active,
  output logic             last,
  output logic             err,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             ilv
);
  logic full;
  assign last = active && !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      err    <= 1'b0;
      full   <= 1'b0;
      ilv    <= 1'b0;
      base   <= '0;
      beat   <= '0;
      mask   <= '0;
    end else if (start) begin
      active <= legal;
      err    <= !legal;
      full   <= full_in;
      ilv    <= ilv_in;
      base   <= start_col;
      beat   <= '0;
      mask   <= mask_in;
    end else begin
      err <= 1'b0;
      if (term) begin
        active <= 1'b0;
      end else if (active && adv) begin
        if (last) active <= 1'b0;
        else      beat   <= beat + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              ilv_mode,
  input  logic              term,
  input  logic              beat_rdy,
  output logic [COL_W-1:0]  col,
  output logic              beat_vld,
  output logic              beat_last,
  output logic              cfg_err
);
  logic             dec_legal, dec_full;
  logic [COL_W-1:0] dec_mask;
  logic [COL_W-1:0] r_base, r_beat, r_mask;
  logic             r_ilv;

  colgen_decode #(.COL_W(COL_W)) u_dec (
    .code(len_code), .ilv(ilv_mode),
    .legal(dec_legal), .full(dec_full), .mask(dec_mask)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_vld), .legal(dec_legal),
    .full_in(dec_full), .mask_in(dec_mask), .ilv_in(ilv_mode),
    .start_col(start_col), .term(term), .adv(beat_rdy),
    .active(beat_vld), .last(beat_last), .err(cfg_err),
    .base(r_base), .beat(r_beat), .mask(r_mask), .ilv(r_ilv)
  );

  colgen_order #(.COL_W(COL_W)) u_ord (
    .base(r_base), .beat(r_beat), .mask(r_mask), .ilv(r_ilv), .col(col)
  );
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_vld,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             ilv_mode,
  input logic             term,
  input logic             beat_rdy,
  input logic [COL_W-1:0] col,
  input logic             beat_vld,
  input logic             beat_last,
  input logic             cfg_err
);
  logic start_ok;
  assign start_ok = start_vld && (len_code <= 3'd3 || (len_code == 3'd7 && !ilv_mode));

  // R7
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_vld);
  // R2
  start_first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> beat_vld && col == $past(start_col));
  // R10
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && !start_ok) |=> cfg_err && !beat_vld);
  // R10
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !start_vld) |=> !cfg_err);
  // R8
  term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !start_vld) |=> !beat_vld);
  // R7
  last_taken_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && beat_rdy && !start_vld) |=> !beat_vld);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_rdy && !start_vld && !term) |=>
      beat_vld && $stable(col) && $stable(beat_last));
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_col(start_col),
  .len_code(len_code), .ilv_mode(ilv_mode), .term(term), .beat_rdy(beat_rdy),
  .col(col), .beat_vld(beat_vld), .beat_last(beat_last), .cfg_err(cfg_err)
);

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_vld = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       ilv_mode = 1'b0;
  logic       term = 1'b0;
  logic       beat_rdy = 1'b0;
  logic [7:0] col;
  logic       beat_vld, beat_last, cfg_err;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_col(start_col),
    .len_code(len_code), .ilv_mode(ilv_mode), .term(term), .beat_rdy(beat_rdy),
    .col(col), .beat_vld(beat_vld), .beat_last(beat_last), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each taken beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && beat_vld && beat_rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected beat col", int'(col), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({beat_last, col} == e, cur_req, "beat {last,col}",
              int'({beat_last, col}), int'(e));
      end
    end
  end

  // endm: 0 natural end, 1 terminate, 2 leave running
  task automatic burst(input logic [7:0] sc, input logic [2:0] code, input bit ilv,
                       input int n, input bit stall, input int endm, input string req);
    int len;
    bit full;
    logic [7:0] msk, low, cv;
    bit ph;
    full = (code == 3'd7);
    len  = full ? 256 : (1 << code);
    msk  = 8'(len - 1);
    for (int k = 0; k < n; k++) begin
      low = ilv ? (sc ^ 8'(k)) : (sc + 8'(k));
      cv  = (sc & ~msk) | (low & msk);
      exp_q.push_back({(!full && k == len - 1), cv});
    end
    cur_req = req;
    @(posedge clk); #1;
    start_vld = 1'b1; start_col = sc; len_code = code; ilv_mode = ilv; beat_rdy = 1'b0;
    @(posedge clk); #1;
    start_vld = 1'b0;
    check(beat_vld == 1'b1 && col == sc, "R2", "first beat", int'(col), int'(sc));
    ph = 1'b0;
    while (exp_q.size() != 0) begin
      beat_rdy = stall ? ph : 1'b1;
      ph = ~ph;
      @(posedge clk); #1;
    end
    beat_rdy = 1'b0;
    if (endm == 0) begin
      check(beat_vld == 1'b0, "R7", "valid after last", int'(beat_vld), 0);
    end else if (endm == 1) begin
      check(beat_vld == 1'b1, "R8", "still running before term", int'(beat_vld), 1);
      term = 1'b1;
      @(posedge clk); #1;
      term = 1'b0;
      check(beat_vld == 1'b0, "R8", "valid after term", int'(beat_vld), 0);
    end
  endtask

  task automatic bad_cfg(input logic [2:0] code, input bit ilv);
    cur_req = "R10";
    @(posedge clk); #1;
    start_vld = 1'b1; start_col = 8'h21; len_code = code; ilv_mode = ilv; beat_rdy = 1'b1;
    @(posedge clk); #1;
    start_vld = 1'b0;
    check(cfg_err == 1'b1 && beat_vld == 1'b0, "R10", "err pulse",
          int'({cfg_err, beat_vld}), 2);
    @(posedge clk); #1;
    check(cfg_err == 1'b0 && beat_vld == 1'b0, "R10", "err cleared, no beats",
          int'({cfg_err, beat_vld}), 0);
    beat_rdy = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, cur_req, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!beat_vld && !beat_last && !cfg_err, "R1", "reset outputs",
          int'({beat_vld, beat_last, cfg_err}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!beat_vld && !cfg_err, "R1", "idle after reset", int'({beat_vld, cfg_err}), 0);

    burst(8'h01, 3'd2, 1'b0, 4, 1'b0, 0, "R3");
    burst(8'h9E, 3'd3, 1'b0, 8, 1'b1, 0, "R3");
    burst(8'h2F, 3'd1, 1'b0, 2, 1'b0, 0, "R3");
    burst(8'h45, 3'd3, 1'b1, 8, 1'b1, 0, "R4");
    burst(8'hB6, 3'd2, 1'b1, 4, 1'b0, 0, "R4");
    burst(8'h2F, 3'd1, 1'b1, 2, 1'b1, 0, "R11");
    burst(8'h33, 3'd0, 1'b1, 1, 1'b0, 0, "R5");
    burst(8'h33, 3'd0, 1'b0, 1, 1'b0, 0, "R5");
    burst(8'hFD, 3'd7, 1'b0, 6, 1'b1, 1, "R6");
    burst(8'h5A, 3'd3, 1'b0, 2, 1'b0, 1, "R8");
    burst(8'h13, 3'd3, 1'b1, 3, 1'b0, 2, "R9");
    burst(8'h42, 3'd2, 1'b1, 4, 1'b0, 0, "R9");
    bad_cfg(3'd5, 1'b0);
    bad_cfg(3'd4, 1'b1);
    bad_cfg(3'd6, 1'b0);
    bad_cfg(3'd7, 1'b1);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule